// File: doc/BRIEF.md
# Egress Word Transmitter with Programmable Back-Pressure Latency

This block sends 32-bit words onto a UTOPIA-3 style transmit bus. Each cycle it can present one word, marked by an active-high send strobe, together with a parity bit. The words come from an upstream source over a valid/ready handshake. Every word that the block accepts appears on the bus in the next cycle, exactly once.

A downstream device holds words back through a full input. The block reacts to that input after a programmable delay of 1 to 4 clock cycles. The full input can be read as active-high or active-low, and flow control can be switched off so that full is ignored. Parity is odd over the data word and can be suppressed. For test, it can also be inverted on purpose.

A six-bit configuration word is written through a write strobe. Reset puts it back to its default value.

Top module: `egressTx`

## Requirements
- R1: While reset is asserted, txEn is low. Reset loads the default configuration: latency code 11, flow control on, active-low full, parity on, forced error off. The default latency is visible after reset: with full held low from the first cycle, inReady stays high for three cycles and then drops.
- R2: Configuration word layout: bits [1:0] latency code, bit 2 flow-control enable, bit 3 full active-high, bit 4 parity enable, bit 5 force parity error. A word written with cfgWr in cycle w governs behaviour from cycle w+1 onward.
- R3: A word accepted in cycle d (inValid and inReady both high) appears on txData with txEn high in cycle d+1. In every other cycle txEn is low, so no word is dropped or repeated.
- R4: Flow control is on and the latency code is n (n from 0 to 3). If full is active in cycle c, txEn is low in cycle c+n+1.
- R5: Flow control is on and full is active-low. inReady in cycle d is high exactly when full was not active in cycle d-n, where code 00 uses the current cycle. Sending therefore resumes in the first cycle after the delayed indication clears.
- R6: With the polarity bit set, full counts as active when txFull is high. With the bit cleared, it counts as active when txFull is low. Apart from that, the R5 timing is the same for both.
- R7: With flow control off, txFull has no effect and inReady is high in every cycle, including cycles that still hold delayed full indications.
- R8: With parity enabled and no forced error, txData together with txPrty has an odd number of ones.
- R9: With the forced-error bit set and parity enabled, txPrty is inverted, so txData together with txPrty has an even number of ones.
- R10: With parity disabled, txPrty is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWr | input | 1 | Configuration write strobe |
| cfgWdata | input | 6 | Configuration word |
| inValid | input | 1 | Upstream word valid |
| inReady | output | 1 | Block accepts the upstream word this cycle |
| inData | input | 32 | Upstream word |
| txEn | output | 1 | Word on txData is being sent (active high) |
| txData | output | 32 | Transmit data |
| txPrty | output | 1 | Transmit parity bit |
| txFull | input | 1 | Back-pressure from the downstream device |

## Verification
The hardest case to reach is full changing level inside the latency window, while flow control, polarity or latency is also being rewritten. This is where stale delayed indications and the edge-accepted word can interact. The stimulus covers all four latency codes with both polarities. In each phase, txFull toggles in short random runs and inValid is held back at random, so full edges land on every offset of the delay window. Directed cases switch flow control off while stalled, and restart from a reset that interrupts a non-default configuration.

// File: rtl/egTxPkg.sv
package egTxPkg;
  localparam int LAT_CODE_W = 2;
  localparam int LAT_MAX    = 1 << LAT_CODE_W;
  localparam int CFG_W      = LAT_CODE_W + 4;

  typedef struct packed {
    logic                  forceErr;
    logic                  parEn;
    logic                  fullHigh;
    logic                  fcEn;
    logic [LAT_CODE_W-1:0] latCode;
  } txCfgT;

  localparam txCfgT CFG_DEFAULT = '{forceErr: 1'b0, parEn: 1'b1, fullHigh: 1'b0,
                                    fcEn: 1'b1, latCode: {LAT_CODE_W{1'b1}}};

  typedef struct packed {
    logic load;
    logic drain;
  } txStrobeT;
endpackage

// File: rtl/egTxCtrl.sv
module egTxCtrl
  import egTxPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             txFull,
  input  logic             inValid,
  output logic             inReady,
  output txCfgT            cfgQ,
  output txStrobeT         strobe
);
  localparam int HIST_D = LAT_MAX - 1;

  logic              fullAct;
  logic [HIST_D-1:0] hist;
  logic              stallSel;
  logic              stall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgQ <= CFG_DEFAULT;
    else if (cfgWr) cfgQ <= txCfgT'(cfgWdata);
  end

  assign fullAct = cfgQ.fullHigh ? txFull : ~txFull;

  // Delay line of polarity-adjusted full, one entry per cycle of age
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist <= '0;
    end else begin
      hist[0] <= fullAct;
      for (int i = 1; i < HIST_D; i++) hist[i] <= hist[i-1];
    end
  end

  always_comb begin
    stallSel = fullAct;
    for (int i = 0; i < HIST_D; i++)
      if (cfgQ.latCode == LAT_CODE_W'(i + 1)) stallSel = hist[i];
  end

  assign stall        = cfgQ.fcEn & stallSel;
  assign inReady      = ~stall;
  assign strobe.load  = inValid & ~stall;
  assign strobe.drain = ~strobe.load;

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWr) |-> (cfgQ == txCfgT'($past(cfgWdata))));
endmodule

// File: rtl/egTxDatapath.sv
module egTxDatapath
  import egTxPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobeT          strobe,
  input  txCfgT             cfgQ,
  input  logic [DATA_W-1:0] inData,
  output logic              txEn,
  output logic [DATA_W-1:0] txData,
  output logic              txPrty
);
  logic oddBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEn   <= 1'b0;
      txData <= '0;
    end else if (strobe.load) begin
      txEn   <= 1'b1;
      txData <= inData;
    end else if (strobe.drain) begin
      txEn   <= 1'b0;
    end
  end

  assign oddBit = ~^txData;
  assign txPrty = cfgQ.parEn & (oddBit ^ cfgQ.forceErr);

  // R8
  odd_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && cfgQ.parEn && !cfgQ.forceErr) |-> (^{txData, txPrty}));

  // R9
  forced_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && cfgQ.parEn && cfgQ.forceErr) |-> !(^{txData, txPrty}));
endmodule

// File: rtl/egressTx.sv
module egressTx
  import egTxPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [CFG_W-1:0]  cfgWdata,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              txEn,
  output logic [DATA_W-1:0] txData,
  output logic              txPrty,
  input  logic              txFull
);
  txCfgT    cfgQ;
  txStrobeT strobe;

  egTxCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgWdata(cfgWdata),
    .txFull(txFull), .inValid(inValid), .inReady(inReady),
    .cfgQ(cfgQ), .strobe(strobe)
  );

  egTxDatapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgQ(cfgQ), .inData(inData),
    .txEn(txEn), .txData(txData), .txPrty(txPrty)
  );

  // Assertion support: cycles since the last configuration write
  logic [2:0] cfgAge;
  logic       faPort;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cfgAge <= '0;
    else if (cfgWr)          cfgAge <= '0;
    else if (cfgAge != 3'd7) cfgAge <= cfgAge + 3'd1;
  end
  assign faPort = cfgQ.fullHigh ? txFull : ~txFull;

  // R3
  send_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && inReady) |-> (txEn && txData == $past(inData)));

  // R3
  no_dup_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid && inReady) |-> !txEn);

  for (genvar k = 1; k <= LAT_MAX; k++) begin : gLatChk
    // R4
    latency_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cfgAge >= 3'd5 && cfgQ.fcEn && cfgQ.latCode == LAT_CODE_W'(k - 1)
       && $past(faPort, k)) |-> !txEn);
  end
endmodule

// File: tb/tb_egressTx.sv
`timescale 1ns/1ps
module tb_egressTx;
  import egTxPkg::*;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWr = 1'b0;
  logic [CFG_W-1:0]  cfgWdata = '0;
  logic              inValid = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic              txFull = 1'b1;
  logic              inReady, txEn, txPrty;
  logic [DATA_W-1:0] txData;

  always #2 clk = ~clk;

  egressTx #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgWdata(cfgWdata),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .txEn(txEn), .txData(txData), .txPrty(txPrty), .txFull(txFull)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  txCfgT             mCfg = CFG_DEFAULT;
  logic [3:0]        mHist = '0;
  logic              mTxEn = 1'b0;
  logic [DATA_W-1:0] mData = '0;
  int                cfgAge = 0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic modelFa(txCfgT c, logic f);
    return c.fullHigh ? f : ~f;
  endfunction

  function automatic logic modelReady();
    logic sel;
    sel = (mCfg.latCode == 2'd0) ? modelFa(mCfg, txFull) : mHist[mCfg.latCode - 2'd1];
    return !(mCfg.fcEn && sel);
  endfunction

  function automatic logic modelPar();
    return mCfg.parEn ? ((~^mData) ^ mCfg.forceErr) : 1'b0;
  endfunction

  // Called just after a falling edge with this cycle's inputs applied
  task automatic step();
    logic rdy;
    string tg;
    #1;
    rdy = modelReady();
    if (rstN) begin
      tg = !mCfg.fcEn ? "R7" : (mCfg.fullHigh ? "R6" : "R5");
      chk(inReady == rdy, tg, inReady, rdy);
      chk(txEn == mTxEn, "R3 txEn", txEn, mTxEn);
      if (mTxEn) chk(txData == mData, "R3 txData", txData, mData);
      tg = !mCfg.parEn ? "R10" : (mCfg.forceErr ? "R9" : "R8");
      chk(txPrty == modelPar(), tg, txPrty, modelPar());
      if (cfgAge >= 6 && mCfg.fcEn && mHist[mCfg.latCode])
        chk(!txEn, "R4 send inside full window", txEn, 0);
    end else begin
      chk(!txEn, "R1 txEn in reset", txEn, 0);
    end
    @(posedge clk);
    if (!rstN) begin
      mCfg = CFG_DEFAULT; mHist = '0; mTxEn = 1'b0; mData = '0; cfgAge = 0;
    end else begin
      mTxEn = inValid && rdy;
      if (mTxEn) mData = inData;
      mHist = {mHist[2:0], modelFa(mCfg, txFull)};
      if (cfgWr) begin
        mCfg = txCfgT'(cfgWdata);
        cfgAge = 0;
      end else if (cfgAge < 100) begin
        cfgAge++;
      end
    end
    @(negedge clk);
  endtask

  task automatic writeCfg(txCfgT c);
    cfgWr = 1'b1;
    cfgWdata = c;
    step();
    cfgWr = 1'b0;
  endtask

  task automatic randCycles(int n, int togDiv);
    for (int i = 0; i < n; i++) begin
      if ($urandom % togDiv == 0) txFull = ~txFull;
      inValid = ($urandom % 4) != 0;
      inData = $urandom;
      step();
    end
  endtask

  task automatic doReset();
    inValid = 1'b0;
    rstN = 1'b0;
    for (int i = 0; i < 3; i++) step();
    rstN = 1'b1;
  endtask

  // Default configuration after reset: full active-low, four-cycle reaction
  task automatic defaultProbe();
    txFull = 1'b0;
    inValid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      inData = $urandom;
      #0.5;
      chk(inReady == (i < 3), "R1 default latency/polarity", inReady, (i < 3));
      step();
    end
    txFull = 1'b1;
    inValid = 1'b0;
    for (int i = 0; i < 5; i++) step();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    txCfgT c;
    void'($urandom(32'd20240611));
    @(negedge clk);
    doReset();
    defaultProbe();

    // Sweep all latency codes and both polarities
    for (int code = 0; code < 4; code++) begin
      for (int pol = 0; pol < 2; pol++) begin
        c = CFG_DEFAULT;
        c.latCode = 2'(code);
        c.fullHigh = pol[0];
        c.parEn = ($urandom % 4) != 0;
        c.forceErr = $urandom % 2;
        writeCfg(c);
        randCycles(250, 5);
        randCycles(100, 2);
      end
    end

    // Parity modes under steady traffic
    for (int pm = 0; pm < 3; pm++) begin
      c = CFG_DEFAULT;
      c.latCode = 2'(pm);
      c.parEn = (pm != 2);
      c.forceErr = (pm == 1);
      writeCfg(c);
      randCycles(120, 6);
    end

    // Flow control off: full ignored even with stale history
    c = CFG_DEFAULT;
    c.latCode = 2'd3;
    txFull = 1'b0;
    inValid = 1'b1;
    writeCfg(c);
    for (int i = 0; i < 6; i++) step();
    c.fcEn = 1'b0;
    writeCfg(c);
    #0.5;
    chk(inReady == 1'b1, "R7 stale history ignored", inReady, 1);
    randCycles(150, 3);

    // Write takes effect in the following cycle
    c = CFG_DEFAULT;
    c.latCode = 2'd0;
    c.fullHigh = 1'b1;
    writeCfg(c);
    txFull = 1'b1;
    inValid = 1'b1;
    c.fcEn = 1'b0;
    cfgWr = 1'b1;
    cfgWdata = c;
    #0.5;
    chk(inReady == 1'b0, "R2 old config in write cycle", inReady, 0);
    step();
    cfgWr = 1'b0;
    #0.5;
    chk(inReady == 1'b1, "R2 new config next cycle", inReady, 1);
    step();

    // Reset in the middle of a non-default setup restores defaults
    c = '{forceErr: 1'b1, parEn: 1'b0, fullHigh: 1'b1, fcEn: 1'b0, latCode: 2'd1};
    writeCfg(c);
    randCycles(40, 3);
    doReset();
    defaultProbe();
    randCycles(200, 4);

    finish();
  end
endmodule